// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit byte logical address into a physical address for a paged memory with 4 KB pages. A caller offers one request at a time. Each request carries the logical address, a read/write flag and a user/supervisor flag. The walker samples the directory base register when it accepts the request. It then fetches a directory entry, which names a page table, and fetches the page table entry, which names the page frame. Both fetches go over a simple word-wide memory request/response port. When the walk ends, the block raises a single-cycle completion pulse. The pulse carries either the translated address or a fault, and the fault gives its cause and the level at which it was found.

Permission checks run on both levels. A store that passes every check and finds the leaf entry clean causes the walker to write the entry back with its dirty flag set before it reports completion. A store to an entry that is already dirty needs no write-back and completes after two reads.

The control is a state machine with eight states:
- `ST_IDLE` goes to `ST_DIR_REQ` when a request is offered.
- `ST_DIR_REQ` goes to `ST_DIR_WAIT` once the memory accepts the read.
- On the response, `ST_DIR_WAIT` goes to `ST_FINISH` if the directory entry faults, and to `ST_TBL_REQ` otherwise.
- `ST_TBL_REQ` goes to `ST_TBL_WAIT` when the memory accepts the read.
- On the response, `ST_TBL_WAIT` goes to `ST_FINISH` if the table entry faults. It goes to `ST_MARK_REQ` for a permitted store to a clean entry. Otherwise it goes to `ST_FINISH`.
- `ST_MARK_REQ` goes to `ST_MARK_WAIT` when the memory accepts the write.
- `ST_MARK_WAIT` goes to `ST_FINISH` when the write is acknowledged.
- `ST_FINISH` returns to `ST_IDLE` after one cycle.

Top module: `ptw_walker`

## Requirements
- R1: The directory entry is read at {dir_base[31:12], 12'h000} + (req_laddr[31:22] << 2). The table entry is read at {directory_entry[31:12], 12'h000} + (req_laddr[21:12] << 2). Every memory address is word aligned.
- R2: A walk that ends without a fault reports fault_cause 0 and phys_addr = {table_entry[31:12], req_laddr[11:0]}.
- R3: An entry whose present flag (bit 0) is clear stops the walk. The walk reports fault_cause 1 and phys_addr 0, and issues no further memory access.
- R4: A user access (req_user = 1) to an entry whose user flag (bit 2) is clear faults with fault_cause 3.
- R5: A store (req_write = 1) to an entry whose writable flag (bit 1) is clear faults with fault_cause 2. This applies to user and supervisor accesses alike.
- R6: Faults follow a fixed priority: not-present before privilege before write protection. A directory entry is checked before the table entry. fault_level is 0 for a directory fault and 1 for a table fault.
- R7: A store that passes all checks and finds the table entry's dirty flag (bit 6) clear writes the table entry with bit 6 set back to the table entry address before completion, leaving all other bits as read. The walk then takes three memory accesses.
- R8: A store to a table entry whose dirty flag is already set, and any read, issues no memory write.
- R9: done is high for exactly one cycle per walk. req_ready is low from acceptance until the cycle after done, and requests offered while busy are ignored.
- R10: While mem_req_valid is high and mem_req_ready is low, the memory request address, write flag and data stay unchanged.
- R11: After reset the walker is idle: req_ready high, mem_req_valid low, done low.
- R12: The directory base and the request fields are sampled when the request is accepted. Later changes to them during a walk have no effect, and dir_base[11:0] is ignored.
- R13: Every accepted memory request receives exactly one mem_rsp_valid pulse in a later cycle. A write is acknowledged the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_laddr | input | 32 | Logical byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| dir_base | input | 32 | Page directory base register, bits 31:12 used |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word address of the entry |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_wdata | output | 32 | Write data (entry with dirty flag set) |
| mem_rsp_valid | input | 1 | Memory response or write acknowledge |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault_cause | output | 2 | 0 none, 1 not present, 2 write protect, 3 privilege |
| fault_level | output | 1 | 0 directory, 1 table |
| phys_addr | output | 32 | Physical address, 0 on a fault |

## Verification
The bench builds the walker with its default widths: a 32-bit address, a 12-bit page offset and two 10-bit indices. These widths let the stimulus reach index 0 and index 1023 at both levels, and a frame in the top page of the address space. A reference memory with hand-placed directory and table entries lets every fault cause be produced at both levels, along with the priority cases in which two flags are missing together. Stores are repeated to the same page, so the first store to a page writes the dirty flag back and the second one finds it already set.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Flag positions inside a directory or table entry
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_DIRTY   = 6;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_WPROT  = 2'd2,
        FLT_PRIV   = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_MARK_REQ,
        ST_MARK_WAIT,
        ST_FINISH
    } walk_state_e;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W      = 32,
    parameter int OFFS_W      = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [ADDR_W-OFFS_W-1:0] frame_i,
    input  logic [IDX_W-1:0]         index_i,
    output logic [ADDR_W-1:0]        entry_addr_o
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);
    localparam int PAD   = ADDR_W - IDX_W - SHIFT;

    logic [ADDR_W-1:0] table_base;
    logic [ADDR_W-1:0] entry_offs;

    // Table base is page aligned; index scaled by entry size
    assign table_base   = {frame_i, {OFFS_W{1'b0}}};
    assign entry_offs   = {{PAD{1'b0}}, index_i, {SHIFT{1'b0}}};
    assign entry_addr_o = table_base + entry_offs;

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic   present_i,
    input  logic   writable_i,
    input  logic   user_ok_i,
    input  logic   is_write_i,
    input  logic   is_user_i,
    output fault_e fault_o
);
    // Priority: absent, then privilege, then write protection
    always_comb begin
        if (!present_i) begin
            fault_o = FLT_ABSENT;
        end else if (is_user_i && !user_ok_i) begin
            fault_o = FLT_PRIV;
        end else if (is_write_i && !writable_i) begin
            fault_o = FLT_WPROT;
        end else begin
            fault_o = FLT_NONE;
        end
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_rdata,
    output logic              done,
    output logic [1:0]        fault_cause,
    output logic              fault_level,
    output logic [ADDR_W-1:0] phys_addr
);
    localparam int FRAME_W = ADDR_W - OFFS_W;
    localparam int LEVELS  = 2;
    localparam logic [ADDR_W-1:0] DIRTY_MASK = ADDR_W'(1) << BIT_DIRTY;

    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0]  la_q;
    logic               wr_q;
    logic               usr_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [ADDR_W-1:0]  pte_q;
    logic [ADDR_W-1:0]  phys_q;
    fault_e             cause_q;
    logic               level_q;

    logic [FRAME_W-1:0] lvl_frame  [LEVELS];
    logic [IDX_W-1:0]   lvl_index  [LEVELS];
    logic [ADDR_W-1:0]  lvl_addr   [LEVELS];
    fault_e             rsp_fault;
    logic               unused_base;

    assign unused_base  = ^dir_base[OFFS_W-1:0];

    assign lvl_frame[0] = dir_frame_q;
    assign lvl_frame[1] = tbl_frame_q;
    assign lvl_index[0] = la_q[ADDR_W-1 -: IDX_W];
    assign lvl_index[1] = la_q[OFFS_W +: IDX_W];

    // One entry-address adder per level
    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_level
            ptw_entry_addr #(
                .ADDR_W (ADDR_W),
                .OFFS_W (OFFS_W),
                .IDX_W  (IDX_W)
            ) u_addr (
                .frame_i      (lvl_frame[g]),
                .index_i      (lvl_index[g]),
                .entry_addr_o (lvl_addr[g])
            );
        end
    endgenerate

    // Shared checker applied to whichever entry is returning
    ptw_perm_check u_perm (
        .present_i  (mem_rsp_rdata[BIT_PRESENT]),
        .writable_i (mem_rsp_rdata[BIT_WRITE]),
        .user_ok_i  (mem_rsp_rdata[BIT_USER]),
        .is_write_i (wr_q),
        .is_user_i  (usr_q),
        .fault_o    (rsp_fault)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid)     state_d = ST_DIR_REQ;
            ST_DIR_REQ:   if (mem_req_ready) state_d = ST_DIR_WAIT;
            ST_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = (rsp_fault != FLT_NONE) ? ST_FINISH : ST_TBL_REQ;
                end
            end
            ST_TBL_REQ:   if (mem_req_ready) state_d = ST_TBL_WAIT;
            ST_TBL_WAIT: begin
                if (mem_rsp_valid) begin
                    if (rsp_fault != FLT_NONE) begin
                        state_d = ST_FINISH;
                    end else if (wr_q && !mem_rsp_rdata[BIT_DIRTY]) begin
                        state_d = ST_MARK_REQ;
                    end else begin
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_MARK_REQ:  if (mem_req_ready) state_d = ST_MARK_WAIT;
            ST_MARK_WAIT: if (mem_rsp_valid) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Walk datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_q        <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            dir_frame_q <= '0;
            tbl_frame_q <= '0;
            pte_q       <= '0;
            phys_q      <= '0;
            cause_q     <= FLT_NONE;
            level_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                la_q        <= req_laddr;
                wr_q        <= req_write;
                usr_q       <= req_user;
                dir_frame_q <= dir_base[ADDR_W-1:OFFS_W];
                cause_q     <= FLT_NONE;
                level_q     <= 1'b0;
                phys_q      <= '0;
            end
            if (state_q == ST_DIR_WAIT && mem_rsp_valid) begin
                tbl_frame_q <= mem_rsp_rdata[ADDR_W-1:OFFS_W];
                if (rsp_fault != FLT_NONE) begin
                    cause_q <= rsp_fault;
                    level_q <= 1'b0;
                end
            end
            if (state_q == ST_TBL_WAIT && mem_rsp_valid) begin
                pte_q <= mem_rsp_rdata;
                if (rsp_fault != FLT_NONE) begin
                    cause_q <= rsp_fault;
                    level_q <= 1'b1;
                end else begin
                    phys_q <= {mem_rsp_rdata[ADDR_W-1:OFFS_W], la_q[OFFS_W-1:0]};
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        done          = (state_q == ST_FINISH);
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        mem_req_write = 1'b0;
        mem_req_wdata = '0;
        unique case (state_q)
            ST_DIR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = lvl_addr[0];
            end
            ST_TBL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = lvl_addr[1];
            end
            ST_MARK_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = lvl_addr[1];
                mem_req_write = 1'b1;
                mem_req_wdata = pte_q | DIRTY_MASK;
            end
            default: ;
        endcase
        fault_cause = cause_q;
        fault_level = level_q;
        phys_addr   = phys_q;
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic [1:0]        fault_cause,
    input logic [ADDR_W-1:0] phys_addr
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R9
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);                                                // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !done));                // R9
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid
            && $stable(mem_req_addr) && $stable(mem_req_write)
            && $stable(mem_req_wdata)));                                    // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);                                      // R11
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));                    // R1
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid));                                     // R13
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_cause != 2'd0) |-> (phys_addr == '0));               // R3

endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0001_0000;

    typedef struct packed {
        logic [31:0] la;
        logic        wr;
        logic        usr;
        logic [1:0]  cause;
        logic        lvl;
        logic [31:0] pa;
        logic [1:0]  nops;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0040_0ABC, 1'b0, 1'b1, 2'd0, 1'b0, 32'h1234_5ABC, 2'd2},
        '{32'h0040_0001, 1'b1, 1'b1, 2'd0, 1'b0, 32'h1234_5001, 2'd3},
        '{32'h0040_0001, 1'b1, 1'b1, 2'd0, 1'b0, 32'h1234_5001, 2'd2},
        '{32'h0040_1010, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0ABC_D010, 2'd2},
        '{32'h0040_1010, 1'b1, 1'b1, 2'd2, 1'b1, 32'h0000_0000, 2'd2},
        '{32'h0040_2000, 1'b0, 1'b0, 2'd1, 1'b1, 32'h0000_0000, 2'd2},
        '{32'h0040_3FFF, 1'b0, 1'b1, 2'd3, 1'b1, 32'h0000_0000, 2'd2},
        '{32'h0040_3FFF, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0777_7FFF, 2'd3},
        '{32'h0040_5004, 1'b1, 1'b1, 2'd3, 1'b1, 32'h0000_0000, 2'd2},
        '{32'h0040_5004, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0666_6004, 2'd2},
        '{32'h0080_0000, 1'b1, 1'b1, 2'd1, 1'b0, 32'h0000_0000, 2'd1},
        '{32'h00C0_0123, 1'b0, 1'b1, 2'd3, 1'b0, 32'h0000_0000, 2'd1},
        '{32'h00C0_0123, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0999_9123, 2'd3},
        '{32'h0100_0456, 1'b1, 1'b0, 2'd2, 1'b0, 32'h0000_0000, 2'd1},
        '{32'h0100_0456, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0888_8456, 2'd2},
        '{32'h0040_4800, 1'b1, 1'b1, 2'd0, 1'b0, 32'h0555_5800, 2'd2},
        '{32'hFFFF_FFFF, 1'b0, 1'b1, 2'd0, 1'b0, 32'hFFFF_FFFF, 2'd2},
        '{32'h0000_0000, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0000_0000, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] dir_base = BASE;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_req_write;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        done;
    logic [1:0]  fault_cause;
    logic        fault_level;
    logic [31:0] phys_addr;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] mem [logic [31:0]];
    int          ops_total = 0;
    logic [31:0] log_addr  [64];
    logic        log_wr    [64];
    logic [31:0] log_wdata [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker dut (.*);

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model: one-cycle response, writes acknowledged (R13)
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            log_addr[ops_total % 64]  <= mem_req_addr;
            log_wr[ops_total % 64]    <= mem_req_write;
            log_wdata[ops_total % 64] <= mem_req_wdata;
            ops_total <= ops_total + 1;
            if (mem_req_write) mem[mem_req_addr] = mem_req_wdata;
            mem_rsp_rdata <= rd(mem_req_addr);
            mem_rsp_valid <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] c);
        case (c)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R5";
            default: return "R4";
        endcase
    endfunction

    // Offer one request, wait for done, sample outputs at the done cycle
    task automatic run_walk(input logic [31:0] la, input logic wr, input logic usr,
                            output logic [31:0] pa, output logic [1:0] cause,
                            output logic lvl, output int nops, output int start);
        int cyc;
        start = ops_total;
        @(negedge clk);
        req_laddr = la; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R9 walk completion", 32'(done), 32'd1);
        pa = phys_addr; cause = fault_cause; lvl = fault_level;
        nops = ops_total - start;
        @(negedge clk);
        chk(!done && req_ready, "R9 done single cycle", {30'd0, done, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] pa, pte_before, dir_a, tbl_a, pde;
        logic [1:0]  cause;
        logic        lvl;
        int          nops, start;

        // Directory at 0x10000
        mem[32'h0001_0004] = 32'h0002_0007;
        mem[32'h0001_0008] = 32'h0003_0000;
        mem[32'h0001_000C] = 32'h0004_0003;
        mem[32'h0001_0010] = 32'h0005_0005;
        mem[32'h0001_0FFC] = 32'h0006_0007;
        // Page tables
        mem[32'h0002_0000] = 32'h1234_5007;
        mem[32'h0002_0004] = 32'h0ABC_D005;
        mem[32'h0002_0008] = 32'h0000_0006;
        mem[32'h0002_000C] = 32'h0777_7003;
        mem[32'h0002_0010] = 32'h0555_5047;
        mem[32'h0002_0014] = 32'h0666_6001;
        mem[32'h0004_0000] = 32'h0999_9007;
        mem[32'h0005_0000] = 32'h0888_8007;
        mem[32'h0006_0FFC] = 32'hFFFF_F007;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk(req_ready == 1'b1, "R11 req_ready in reset", 32'(req_ready), 32'd1);
        chk(mem_req_valid == 1'b0, "R11 no memory request", 32'(mem_req_valid), 32'd0);
        chk(done == 1'b0, "R11 done low", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !done, "R11 idle after reset",
            {29'd0, req_ready, mem_req_valid, done}, 32'd4);

        // Table-driven walks
        for (int i = 0; i < NVEC; i++) begin
            dir_a = BASE + {20'd0, VECS[i].la[31:22], 2'b00};
            pde   = rd(dir_a);
            tbl_a = {pde[31:12], 12'h000} + {20'd0, VECS[i].la[21:12], 2'b00};
            pte_before = rd(tbl_a);
            run_walk(VECS[i].la, VECS[i].wr, VECS[i].usr, pa, cause, lvl, nops, start);
            chk(cause == VECS[i].cause, tag_of(VECS[i].cause), 32'(cause), 32'(VECS[i].cause));
            chk(lvl == VECS[i].lvl, "R6 fault level", 32'(lvl), 32'(VECS[i].lvl));
            chk(pa == VECS[i].pa, "R2 physical address", pa, VECS[i].pa);
            chk(nops == int'(VECS[i].nops), "R3 R7 R8 memory access count",
                32'(nops), 32'(VECS[i].nops));
            chk(log_addr[start % 64] == dir_a, "R1 directory entry address",
                log_addr[start % 64], dir_a);
            if (nops >= 2) begin
                chk(log_addr[(start + 1) % 64] == tbl_a, "R1 table entry address",
                    log_addr[(start + 1) % 64], tbl_a);
                chk(!log_wr[(start + 1) % 64], "R8 table access is a read",
                    32'(log_wr[(start + 1) % 64]), 32'd0);
            end
            if (nops == 3) begin
                chk(log_wr[(start + 2) % 64] && log_addr[(start + 2) % 64] == tbl_a,
                    "R7 dirty write target", log_addr[(start + 2) % 64], tbl_a);
                chk(log_wdata[(start + 2) % 64] == (pte_before | 32'h40),
                    "R7 dirty write data", log_wdata[(start + 2) % 64], pte_before | 32'h40);
            end
        end

        // R12: base low bits ignored, base and request changed mid-walk
        @(negedge clk);
        dir_base = BASE | 32'h0000_0ABC;
        req_laddr = 32'h0040_1234; req_write = 1'b0; req_user = 1'b1; req_valid = 1'b1;
        start = ops_total;
        @(negedge clk);
        req_valid = 1'b0;
        dir_base = 32'h7777_7000; req_laddr = 32'h0080_0000; req_user = 1'b1; req_write = 1'b1;
        while (!done) @(negedge clk);
        chk(phys_addr == 32'h0ABC_D234 && fault_cause == 2'd0, "R12 captured request",
            phys_addr, 32'h0ABC_D234);
        chk(log_addr[start % 64] == 32'h0001_0004, "R12 captured directory base",
            log_addr[start % 64], 32'h0001_0004);
        dir_base = BASE;
        @(negedge clk);

        // R9: request held valid through the walk is not taken twice
        start = ops_total;
        req_laddr = 32'h0040_0010; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_laddr = 32'h0080_0000;
        chk(!req_ready, "R9 busy after accept", 32'(req_ready), 32'd0);
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        chk(phys_addr == 32'h1234_5010, "R9 first request served", phys_addr, 32'h1234_5010);
        repeat (4) @(negedge clk);
        chk(ops_total - start == 2, "R9 busy request ignored", 32'(ops_total - start), 32'd2);
        chk(!done && req_ready, "R9 idle afterwards", {30'd0, done, req_ready}, 32'd1);

        // R10: memory stall holds the request
        mem_req_ready = 1'b0;
        req_laddr = 32'h00C0_0000; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(mem_req_valid && mem_req_addr == 32'h0001_000C, "R10 stalled request held",
                mem_req_addr, 32'h0001_000C);
            @(negedge clk);
        end
        mem_req_ready = 1'b1;
        while (!done) @(negedge clk);
        chk(phys_addr == 32'h0999_9000 && fault_cause == 2'd0, "R10 result after stall",
            phys_addr, 32'h0999_9000);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule